// File: doc/BRIEF.md
# Notification Queue Writer

This block turns remote-memory operation events into 128-bit notification entries and appends them to per-context ring buffers in host memory. Three pipeline stages (requester, responder, completer) each present an event carrying a context number, a 9-bit opcode, source and destination IDs, a three-bit stage-enable vector, an interrupt flag, a 64-bit address-or-payload word and an 8-bit extra byte. For the selected event the block decides whether an entry is due at that stage. If it is, the block formats the entry, computes its host address from the context's ring base and write pointer, and issues one write over a ready/valid memory port.

Each context owns a ring of `2**RING_LOG2` entries of 16 bytes. Software sets a ring's base address and moves its read pointer through a small register write port. The writer stalls an event that would fill the ring. When the event asks for it, the writer pulses an interrupt as the entry is handed to memory. Events that arrive together are taken one per cycle, and the completer stage always goes first.

Top module: `nqw_top`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `memValid`, `irqOut` and every `evtReady` bit are low.
- R2: A stage's event is due only when its own enable bit is set: bit 0 for the requester, bit 1 for the responder and bit 2 for the completer. The stage index is the same, with requester 0, responder 1 and completer 2. An event that is not due is consumed, with its `evtReady` high in that cycle, and produces no memory write.
- R3: An opcode whose low three bits are 0, 2, 4 or 5 is put-type. A responder event of put-type never produces a write, whatever its enable bit 1 says. Other low codes (1, 3, 6, 7) are handled normally.
- R4: The entry has the following layout. `[63:0]` is the payload. `[71:64]` is the extra byte. `[80:72]` is the full opcode. `[82:81]` is the stage code: 1 for requester, 2 for responder, 3 for completer. `[95:83]` is zero. `[111:96]` is the source ID and `[127:112]` is the destination ID.
- R5: The extra byte is carried only for a notification put, which has low opcode code 5. For every other opcode, bits `[71:64]` are zero.
- R6: The entry address is the context's base plus 16 times its write pointer. The write pointer starts at 0, advances by one for each entry written, and wraps modulo the ring depth (8 by default).
- R7: A due event for a context whose write pointer plus one equals its read pointer (modulo the depth) is held with `evtReady` low. It is accepted once the read pointer moves.
- R8: When several stages are valid in the same cycle, only one is granted. The completer is preferred over the responder, and the responder over the requester, so entries reach memory in that order.
- R9: A write request keeps `memValid`, `memAddr` and `memData` steady until `memReady` is seen. While a request waits unacknowledged, no new due event is accepted.
- R10: `irqOut` is high for exactly the cycle in which an entry whose event carried the interrupt flag completes its memory handshake. In that cycle `irqCtx` gives the entry's context. At all other times `irqOut` is low.
- R11: A register write with `regSel`=0 loads the ring base of context `regCtx` from `regData`. With `regSel`=1 it loads that context's read pointer from the low `RING_LOG2` bits. Both registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 3 | Per-stage event valid (0 requester, 1 responder, 2 completer) |
| evtCtx | input | 3x2 | Per-stage context number |
| evtOpcode | input | 3x9 | Per-stage opcode; low three bits give the command |
| evtSrcId | input | 3x16 | Per-stage source ID |
| evtDstId | input | 3x16 | Per-stage destination ID |
| evtEnable | input | 3x3 | Per-stage enable vector, one bit per stage |
| evtIrq | input | 3 | Per-stage interrupt request flag |
| evtPayload | input | 3x64 | Per-stage memory address or carried data |
| evtExtra | input | 3x8 | Per-stage extra byte for notification put |
| evtReady | output | 3 | Per-stage event consumed this cycle |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the ring base, 1 selects the read pointer |
| regCtx | input | 2 | Context addressed by the register write |
| regData | input | 48 | Register write data |
| memValid | output | 1 | Host memory write request valid |
| memReady | input | 1 | Host memory accepts the write |
| memAddr | output | 48 | Byte address of the entry |
| memData | output | 128 | Formatted entry |
| irqOut | output | 1 | Interrupt pulse at the handshake of a flagged entry |
| irqCtx | output | 2 | Context of the interrupting entry |

## Verification
The properties assume that a stage holds its event fields steady while its valid is high and until its ready is seen. They also assume that read pointers are moved only to slots the writer has already filled, so that the ring arithmetic describes a real queue. The stimulus holds every event, unchanged, until it is granted. It sets read pointers only to values at or ahead of the modelled write pointer that leave the ring legal. Memory back-pressure is applied by dropping `memReady` at arbitrary points, which the design must tolerate in any cycle.

// File: rtl/nqw_pkg.sv
`timescale 1ns/1ps
package nqw_pkg;
  parameter int CTX_NUM   = 4;
  parameter int RING_LOG2 = 3;
  parameter int ADDR_W    = 48;
  parameter int OP_W      = 9;
  parameter int ID_W      = 16;
  parameter int PAY_W     = 64;
  parameter int EXT_W     = 8;
  parameter int NSTG      = 3;
  parameter int ENTRY_W   = 128;

  localparam int CTX_W      = $clog2(CTX_NUM);
  localparam int STG_W      = $clog2(NSTG + 1);
  localparam int CMD_W      = 3;
  localparam int SLOT_SHIFT = $clog2(ENTRY_W / 8);
  localparam int PAD_W      = ENTRY_W - PAY_W - EXT_W - OP_W - STG_W - 2 * ID_W;

  localparam int STG_RSP = 1;

  localparam logic [CMD_W-1:0] CMD_PUT_WORD  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_PUT_LINE  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_PUT_IMM   = 3'd4;
  localparam logic [CMD_W-1:0] CMD_PUT_NOTIF = 3'd5;

  typedef struct packed {
    logic                 load;
    logic [STG_W-1:0]     stage;
    logic [RING_LOG2-1:0] slot;
    logic [CTX_W-1:0]     ctx;
  } strobe_t;

  function automatic logic isPutCmd(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_PUT_WORD) || (cmd == CMD_PUT_LINE) ||
           (cmd == CMD_PUT_IMM)  || (cmd == CMD_PUT_NOTIF);
  endfunction

  function automatic logic isNotifPut(input logic [CMD_W-1:0] cmd);
    return cmd == CMD_PUT_NOTIF;
  endfunction
endpackage

// File: rtl/nqw_ctrl.sv
`timescale 1ns/1ps
module nqw_ctrl
  import nqw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NSTG-1:0]         evtValid,
  input  logic [NSTG*CTX_W-1:0]   evtCtx,
  input  logic [NSTG*CMD_W-1:0]   evtCmd,
  input  logic [NSTG*NSTG-1:0]    evtEnable,
  input  logic                    outBusy,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [CTX_W-1:0]        regCtx,
  input  logic [RING_LOG2-1:0]    regPtr,
  output logic [NSTG-1:0]         evtReady,
  output strobe_t                 strobe
);
  logic [RING_LOG2-1:0] wrPtr [CTX_NUM];
  logic [RING_LOG2-1:0] rdPtr [CTX_NUM];

  logic [STG_W-1:0] sel;
  logic             anyValid;
  logic [CTX_W-1:0] selCtx;
  logic [CMD_W-1:0] selCmd;
  logic [NSTG-1:0]  selEn;
  logic             due;
  logic             ringFull;
  logic             accept;

  // fixed priority: the highest stage index wins
  always_comb begin
    sel = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (evtValid[s]) sel = STG_W'(s);
    end
  end

  assign anyValid = |evtValid;
  assign selCtx   = evtCtx[sel*CTX_W +: CTX_W];
  assign selCmd   = evtCmd[sel*CMD_W +: CMD_W];
  assign selEn    = evtEnable[sel*NSTG +: NSTG];

  assign due      = selEn[sel] && !((sel == STG_W'(STG_RSP)) && isPutCmd(selCmd));
  assign ringFull = (RING_LOG2'(wrPtr[selCtx] + 1'b1)) == rdPtr[selCtx];
  assign accept   = anyValid && (!due || (!ringFull && !outBusy));

  assign evtReady = accept ? (NSTG'(1) << sel) : '0;

  always_comb begin
    strobe.load  = accept && due;
    strobe.stage = sel;
    strobe.slot  = wrPtr[selCtx];
    strobe.ctx   = selCtx;
  end

  for (genvar g = 0; g < CTX_NUM; g++) begin : g_ring
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr[g] <= '0;
        rdPtr[g] <= '0;
      end else begin
        if (strobe.load && (selCtx == CTX_W'(g)))
          wrPtr[g] <= RING_LOG2'(wrPtr[g] + 1'b1);
        if (regWrEn && regSel && (regCtx == CTX_W'(g)))
          rdPtr[g] <= regPtr;
      end
    end
  end
endmodule

// File: rtl/nqw_dp.sv
`timescale 1ns/1ps
module nqw_dp
  import nqw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [NSTG*OP_W-1:0]    evtOpcode,
  input  logic [NSTG*ID_W-1:0]    evtSrcId,
  input  logic [NSTG*ID_W-1:0]    evtDstId,
  input  logic [NSTG-1:0]         evtIrq,
  input  logic [NSTG*PAY_W-1:0]   evtPayload,
  input  logic [NSTG*EXT_W-1:0]   evtExtra,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [CTX_W-1:0]        regCtx,
  input  logic [ADDR_W-1:0]       regData,
  input  logic                    memReady,
  output logic                    memValid,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ENTRY_W-1:0]      memData,
  output logic                    outBusy,
  output logic                    irqOut,
  output logic [CTX_W-1:0]        irqCtx
);
  logic [ADDR_W-1:0] baseReg [CTX_NUM];

  logic [OP_W-1:0]    opSel;
  logic [ID_W-1:0]    srcSel;
  logic [ID_W-1:0]    dstSel;
  logic [PAY_W-1:0]   paySel;
  logic [EXT_W-1:0]   extSel;
  logic [STG_W-1:0]   stageCode;
  logic [ENTRY_W-1:0] entry;
  logic [ADDR_W-1:0]  entryAddr;
  logic               irqPend;

  for (genvar g = 0; g < CTX_NUM; g++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rstN)
        baseReg[g] <= '0;
      else if (regWrEn && !regSel && (regCtx == CTX_W'(g)))
        baseReg[g] <= regData;
    end
  end

  always_comb begin
    opSel     = evtOpcode[strobe.stage*OP_W +: OP_W];
    srcSel    = evtSrcId[strobe.stage*ID_W +: ID_W];
    dstSel    = evtDstId[strobe.stage*ID_W +: ID_W];
    paySel    = evtPayload[strobe.stage*PAY_W +: PAY_W];
    extSel    = isNotifPut(opSel[CMD_W-1:0]) ? evtExtra[strobe.stage*EXT_W +: EXT_W] : '0;
    stageCode = STG_W'(strobe.stage + 1'b1);
    entry     = {dstSel, srcSel, {PAD_W{1'b0}}, stageCode, opSel, extSel, paySel};
    entryAddr = baseReg[strobe.ctx] + ADDR_W'({strobe.slot, {SLOT_SHIFT{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      irqPend  <= 1'b0;
      irqCtx   <= '0;
    end else if (strobe.load) begin
      memValid <= 1'b1;
      memAddr  <= entryAddr;
      memData  <= entry;
      irqPend  <= evtIrq[strobe.stage];
      irqCtx   <= strobe.ctx;
    end else if (memReady) begin
      memValid <= 1'b0;
    end
  end

  assign outBusy = memValid && !memReady;
  assign irqOut  = memValid && memReady && irqPend;
endmodule

// File: rtl/nqw_top.sv
`timescale 1ns/1ps
module nqw_top
  import nqw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NSTG-1:0]         evtValid,
  input  logic [NSTG*CTX_W-1:0]   evtCtx,
  input  logic [NSTG*OP_W-1:0]    evtOpcode,
  input  logic [NSTG*ID_W-1:0]    evtSrcId,
  input  logic [NSTG*ID_W-1:0]    evtDstId,
  input  logic [NSTG*NSTG-1:0]    evtEnable,
  input  logic [NSTG-1:0]         evtIrq,
  input  logic [NSTG*PAY_W-1:0]   evtPayload,
  input  logic [NSTG*EXT_W-1:0]   evtExtra,
  output logic [NSTG-1:0]         evtReady,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [CTX_W-1:0]        regCtx,
  input  logic [ADDR_W-1:0]       regData,
  output logic                    memValid,
  input  logic                    memReady,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ENTRY_W-1:0]      memData,
  output logic                    irqOut,
  output logic [CTX_W-1:0]        irqCtx
);
  strobe_t                strobe;
  logic                   outBusy;
  logic [NSTG*CMD_W-1:0]  evtCmd;

  for (genvar s = 0; s < NSTG; s++) begin : g_cmd
    assign evtCmd[s*CMD_W +: CMD_W] = evtOpcode[s*OP_W +: CMD_W];
  end

  nqw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtValid  (evtValid),
    .evtCtx    (evtCtx),
    .evtCmd    (evtCmd),
    .evtEnable (evtEnable),
    .outBusy   (outBusy),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regCtx    (regCtx),
    .regPtr    (regData[RING_LOG2-1:0]),
    .evtReady  (evtReady),
    .strobe    (strobe)
  );

  nqw_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evtOpcode  (evtOpcode),
    .evtSrcId   (evtSrcId),
    .evtDstId   (evtDstId),
    .evtIrq     (evtIrq),
    .evtPayload (evtPayload),
    .evtExtra   (evtExtra),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regCtx     (regCtx),
    .regData    (regData),
    .memReady   (memReady),
    .memValid   (memValid),
    .memAddr    (memAddr),
    .memData    (memData),
    .outBusy    (outBusy),
    .irqOut     (irqOut),
    .irqCtx     (irqCtx)
  );
endmodule

// File: rtl/nqw_chk.sv
`timescale 1ns/1ps
module nqw_chk
  import nqw_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [NSTG-1:0]     evtValid,
  input logic [NSTG-1:0]     evtReady,
  input logic                memValid,
  input logic                memReady,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [ENTRY_W-1:0]  memData,
  input logic                irqOut
);
  localparam int OP_LSB  = PAY_W + EXT_W;
  localparam int STG_LSB = PAY_W + EXT_W + OP_W;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  p_irq_handshake_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (memValid && memReady));

  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtReady & ~evtValid) == '0);

  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evtReady));

  p_completer_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtValid[NSTG-1] |-> (evtReady[NSTG-2:0] == '0));

  p_rsp_put_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && (memData[STG_LSB +: STG_W] == STG_W'(STG_RSP + 1)))
      |-> !isPutCmd(memData[OP_LSB +: CMD_W]));
endmodule

bind nqw_top nqw_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtValid (evtValid),
  .evtReady (evtReady),
  .memValid (memValid),
  .memReady (memReady),
  .memAddr  (memAddr),
  .memData  (memData),
  .irqOut   (irqOut)
);

// File: tb/nqw_top_tb.sv
`timescale 1ns/1ps
module nqw_top_tb;
  import nqw_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [NSTG-1:0]        evtValid;
  logic [NSTG*CTX_W-1:0]  evtCtx;
  logic [NSTG*OP_W-1:0]   evtOpcode;
  logic [NSTG*ID_W-1:0]   evtSrcId;
  logic [NSTG*ID_W-1:0]   evtDstId;
  logic [NSTG*NSTG-1:0]   evtEnable;
  logic [NSTG-1:0]        evtIrq;
  logic [NSTG*PAY_W-1:0]  evtPayload;
  logic [NSTG*EXT_W-1:0]  evtExtra;
  logic [NSTG-1:0]        evtReady;
  logic                   regWrEn;
  logic                   regSel;
  logic [CTX_W-1:0]       regCtx;
  logic [ADDR_W-1:0]      regData;
  logic                   memValid;
  logic                   memReady;
  logic [ADDR_W-1:0]      memAddr;
  logic [ENTRY_W-1:0]     memData;
  logic                   irqOut;
  logic [CTX_W-1:0]       irqCtx;

  always #2.5 clk = ~clk;

  nqw_top u_dut (.*);

  int total = 0;
  int bad = 0;
  int strayIrq = 0;
  bit finished = 0;

  // write log taken from the memory port
  logic [ADDR_W-1:0]  logAddr [64];
  logic [ENTRY_W-1:0] logData [64];
  logic               logIrq  [64];
  logic [CTX_W-1:0]   logIrqCtx [64];
  int logN = 0;

  always @(negedge clk) begin
    #1;
    if (rstN && memValid && memReady && logN < 64) begin
      logAddr[logN]   = memAddr;
      logData[logN]   = memData;
      logIrq[logN]    = irqOut;
      logIrqCtx[logN] = irqCtx;
      logN++;
    end
    if (rstN && irqOut && !(memValid && memReady)) strayIrq++;
  end

  // bench reference state
  logic [ADDR_W-1:0]    bBase [CTX_NUM];
  logic [RING_LOG2-1:0] bPtr  [CTX_NUM];

  // vector: {stage[1:0], cmd[2:0], enable[2:0], irq, ctx[1:0], expectWrite}
  localparam int NVEC = 12;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 3'b001, 1'b0, 2'd0, 1'b1},
    {2'd0, 3'd1, 3'b110, 1'b0, 2'd0, 1'b0},
    {2'd1, 3'd1, 3'b010, 1'b0, 2'd1, 1'b1},
    {2'd1, 3'd4, 3'b010, 1'b0, 2'd1, 1'b0},
    {2'd1, 3'd5, 3'b111, 1'b1, 2'd1, 1'b0},
    {2'd2, 3'd5, 3'b100, 1'b1, 2'd2, 1'b1},
    {2'd2, 3'd2, 3'b011, 1'b0, 2'd2, 1'b0},
    {2'd2, 3'd3, 3'b100, 1'b1, 2'd3, 1'b1},
    {2'd1, 3'd3, 3'b010, 1'b1, 2'd3, 1'b1},
    {2'd0, 3'd6, 3'b001, 1'b0, 2'd1, 1'b1},
    {2'd1, 3'd6, 3'b010, 1'b0, 2'd0, 1'b1},
    {2'd0, 3'd5, 3'b001, 1'b0, 2'd0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [ENTRY_W-1:0] act,
                       input logic [ENTRY_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mkEntry(input int stg, input logic [OP_W-1:0] op,
      input logic [ID_W-1:0] src, input logic [ID_W-1:0] dst,
      input logic [PAY_W-1:0] pay, input logic [EXT_W-1:0] ext);
    logic [EXT_W-1:0] e;
    e = (op[2:0] == 3'd5) ? ext : '0;
    return {dst, src, 13'd0, 2'(stg + 1), op, e, pay};
  endfunction

  task automatic setEvt(input int s, input int ctx, input logic [OP_W-1:0] op,
      input logic [2:0] en, input bit irq, input logic [PAY_W-1:0] pay,
      input logic [EXT_W-1:0] ext, input logic [ID_W-1:0] src, input logic [ID_W-1:0] dst);
    evtCtx[s*CTX_W +: CTX_W]     = CTX_W'(ctx);
    evtOpcode[s*OP_W +: OP_W]    = op;
    evtEnable[s*NSTG +: NSTG]    = en;
    evtIrq[s]                    = irq;
    evtPayload[s*PAY_W +: PAY_W] = pay;
    evtExtra[s*EXT_W +: EXT_W]   = ext;
    evtSrcId[s*ID_W +: ID_W]     = src;
    evtDstId[s*ID_W +: ID_W]     = dst;
  endtask

  // called at a falling edge; holds each valid event until granted
  task automatic drain();
    logic [NSTG-1:0] acc;
    int guard = 0;
    while (evtValid != '0 && guard < 1000) begin
      #1 acc = evtValid & evtReady;
      @(negedge clk);
      evtValid = evtValid & ~acc;
      guard++;
    end
  endtask

  task automatic regWrite(input bit sel, input int ctx, input logic [ADDR_W-1:0] d);
    regWrEn = 1'b1;
    regSel  = sel;
    regCtx  = CTX_W'(ctx);
    regData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectWrite(input int idx, input int ctx, input logic [ENTRY_W-1:0] ent,
                             input bit irq, input string tag);
    logic [ADDR_W-1:0] ea;
    ea = bBase[ctx] + ADDR_W'({bPtr[ctx], 4'b0000});
    check(logAddr[idx] == ea, {tag, " R6 R11 address"}, ENTRY_W'(logAddr[idx]), ENTRY_W'(ea));
    check(logData[idx] == ent, {tag, " R4 R5 entry"}, logData[idx], ent);
    check(logIrq[idx] == irq, {tag, " R10 irq at handshake"}, ENTRY_W'(logIrq[idx]), ENTRY_W'(irq));
    if (irq)
      check(logIrqCtx[idx] == CTX_W'(ctx), {tag, " R10 irqCtx"}, ENTRY_W'(logIrqCtx[idx]), ENTRY_W'(ctx));
    bPtr[ctx] = RING_LOG2'(bPtr[ctx] + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int n0;
    logic [ENTRY_W-1:0] ent;
    logic [ADDR_W-1:0]  holdAddr;
    rstN = 1'b0; evtValid = '0; evtCtx = '0; evtOpcode = '0; evtSrcId = '0; evtDstId = '0;
    evtEnable = '0; evtIrq = '0; evtPayload = '0; evtExtra = '0;
    regWrEn = 1'b0; regSel = 1'b0; regCtx = '0; regData = '0; memReady = 1'b1;
    for (int c = 0; c < CTX_NUM; c++) begin
      bBase[c] = 48'h10_0000_0000 + ADDR_W'(c) * 48'h1_0100;
      bPtr[c]  = '0;
    end
    repeat (3) @(negedge clk);
    #1 check(!memValid && !irqOut && evtReady == '0, "R1 during reset",
             ENTRY_W'({memValid, irqOut, evtReady}), '0);
    @(negedge clk);
    rstN = 1'b1;
    #1 check(!memValid && !irqOut && evtReady == '0, "R1 after reset",
             ENTRY_W'({memValid, irqOut, evtReady}), '0);
    @(negedge clk);

    for (int c = 0; c < CTX_NUM; c++) regWrite(1'b0, c, bBase[c]);

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      int stg, ctx;
      logic [OP_W-1:0] op;
      stg = int'(VEC[i][11:10]);
      ctx = int'(VEC[i][2:1]);
      op  = {6'(i + 5), VEC[i][9:7]};
      setEvt(stg, ctx, op, VEC[i][6:4], VEC[i][3], 64'hA500_0000_0000_0000 | 64'(i),
             8'h40 + 8'(i), 16'h1000 + 16'(i), 16'h2000 + 16'(i));
      n0 = logN;
      evtValid[stg] = 1'b1;
      drain();
      repeat (3) @(negedge clk);
      check(logN - n0 == int'(VEC[i][0]), $sformatf("R2 R3 vector %0d write count", i),
            ENTRY_W'(logN - n0), ENTRY_W'(VEC[i][0]));
      if (VEC[i][0] && logN > n0) begin
        ent = mkEntry(stg, op, 16'h1000 + 16'(i), 16'h2000 + 16'(i),
                      64'hA500_0000_0000_0000 | 64'(i), 8'h40 + 8'(i));
        expectWrite(n0, ctx, ent, VEC[i][3], $sformatf("vector %0d", i));
      end
    end

    // same-cycle events on all stages, all due, context 0
    n0 = logN;
    for (int s = 0; s < NSTG; s++)
      setEvt(s, 0, 9'h001, 3'b111, 1'b0, 64'hB0 + 64'(s), 8'h00, 16'h0300 + 16'(s), 16'h0400);
    evtValid = '1;
    drain();
    repeat (3) @(negedge clk);
    check(logN - n0 == 3, "R8 three entries", ENTRY_W'(logN - n0), 3);
    for (int k = 0; k < 3; k++) begin
      int s;
      s = 2 - k;
      ent = mkEntry(s, 9'h001, 16'h0300 + 16'(s), 16'h0400, 64'hB0 + 64'(s), 8'h00);
      expectWrite(n0 + k, 0, ent, 1'b0, $sformatf("R8 order slot %0d", k));
    end

    // full ring on context 3
    regWrite(1'b1, 3, ADDR_W'(RING_LOG2'(bPtr[3] + 1)));
    n0 = logN;
    setEvt(2, 3, 9'h003, 3'b100, 1'b0, 64'hC0FFEE, 8'h00, 16'h0011, 16'h0022);
    evtValid[2] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1 check(evtReady == '0, "R7 stalled while full", ENTRY_W'(evtReady), '0);
      @(negedge clk);
    end
    check(logN == n0, "R7 no write while full", ENTRY_W'(logN - n0), 0);
    regWrite(1'b1, 3, ADDR_W'(RING_LOG2'(bPtr[3] + 3)));
    drain();
    repeat (3) @(negedge clk);
    check(logN - n0 == 1, "R7 accepted after read pointer moved", ENTRY_W'(logN - n0), 1);
    if (logN > n0)
      expectWrite(n0, 3, mkEntry(2, 9'h003, 16'h0011, 16'h0022, 64'hC0FFEE, 8'h00), 1'b0, "R7");

    // wrap on context 2
    for (int k = 0; k < 8; k++) begin
      logic wrapSlot;
      wrapSlot = (bPtr[2] == '0);
      regWrite(1'b1, 2, ADDR_W'(RING_LOG2'(bPtr[2] + 4)));
      n0 = logN;
      setEvt(0, 2, 9'h000, 3'b001, 1'b0, 64'hD0 + 64'(k), 8'h77, 16'h0055, 16'h0066);
      evtValid[0] = 1'b1;
      drain();
      repeat (3) @(negedge clk);
      if (logN > n0) begin
        if (wrapSlot)
          check(logAddr[n0] == bBase[2], "R6 wrap back to base",
                ENTRY_W'(logAddr[n0]), ENTRY_W'(bBase[2]));
        expectWrite(n0, 2, mkEntry(0, 9'h000, 16'h0055, 16'h0066, 64'hD0 + 64'(k), 8'h77),
                    1'b0, $sformatf("R6 wrap step %0d", k));
      end else
        check(1'b0, "R6 wrap write missing", 0, 1);
    end

    // memory back-pressure on context 1
    memReady = 1'b0;
    n0 = logN;
    holdAddr = bBase[1] + ADDR_W'({bPtr[1], 4'b0000});
    setEvt(2, 1, 9'h001, 3'b100, 1'b1, 64'hE1, 8'h00, 16'h0A0A, 16'h0B0B);
    evtValid[2] = 1'b1;
    drain();
    setEvt(0, 1, 9'h000, 3'b001, 1'b0, 64'hE2, 8'h00, 16'h0C0C, 16'h0D0D);
    evtValid[0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check(memValid && memAddr == holdAddr, "R9 request held",
            ENTRY_W'({memValid, memAddr}), ENTRY_W'({1'b1, holdAddr}));
      check(evtReady == '0, "R9 no accept while busy", ENTRY_W'(evtReady), '0);
      check(!irqOut, "R10 no irq before handshake", ENTRY_W'(irqOut), 0);
      @(negedge clk);
    end
    memReady = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check(logN - n0 == 2, "R9 both entries written", ENTRY_W'(logN - n0), 2);
    if (logN - n0 == 2) begin
      expectWrite(n0, 1, mkEntry(2, 9'h001, 16'h0A0A, 16'h0B0B, 64'hE1, 8'h00), 1'b1, "R9 first");
      expectWrite(n0 + 1, 1, mkEntry(0, 9'h000, 16'h0C0C, 16'h0D0D, 64'hE2, 8'h00), 1'b0, "R9 second");
    end

    check(strayIrq == 0, "R10 no stray interrupt", ENTRY_W'(strayIrq), 0);
    summary();
  end
endmodule